// File: doc/BRIEF.md
# Per-Page Interrupt Priority Selector

This block keeps interrupt state for a set of independent pages. Each page has one pending bit and one enable bit for every interrupt identity, a delivery register that gates its output line, and a threshold register that limits which identities may compete. For each page the block finds the highest-priority identity that is both pending and enabled, where a lower identity number means a higher priority. It drives one interrupt line per page.

Software or a neighbouring block reaches the state through one request port. A request carries a page index, a register selector, a word index, write data and a per-bit write mask. Reads come back combinationally on the same cycle as the request. Writes take effect at the clock edge. Writing the top-identity register with any nonzero mask claims the winner: its pending bit is cleared.

Top module: `page_irq_selector`

## Requirements
- R1: Reset clears every pending bit, enable bit, delivery register and threshold register of every page. After reset all lines on `irq_o` are low and every register reads zero.
- R2: Selector 3 addresses pending words and selector 4 addresses enable words. Word `req_index` holds identities 32·index to 32·index+31, with bit j holding identity 32·index+j. A write changes only the bits whose mask bit is set. Bit 0 of word 0 (identity 0) always reads zero and cannot be set. A word index at or above NUM_IDS/32 reads zero and ignores writes.
- R3: Selector 2 reads the top-identity value. It is the smallest identity from 1 upward that is both pending and enabled, placed once in bits 26:16 and once in bits 10:0, with all other bits zero. It reads 0 when no identity is eligible.
- R4: Let T be the threshold. When T is nonzero and not greater than NUM_IDS, only identities below T are eligible. When T is zero or greater than NUM_IDS, every implemented identity is eligible.
- R5: Selector 1 is the threshold register and holds bits 10:0 only. A write updates only masked bits, and bits 31:11 always read zero. Selector 0 is the 32-bit delivery register, which is written under the mask as a read-modify-write.
- R6: `irq_o[p]` is high exactly when page p's delivery register is nonzero and its top-identity value is nonzero. The line reflects a state change at the first sample after the clock edge that made the change.
- R7: A write to selector 2 with a nonzero mask ignores its data and clears only the pending bit of the current winner. When there is no winner, or the mask is zero, the write changes nothing.
- R8: Pages are independent: a write to one page changes no state of any other page. A request whose page index is NUM_PAGES or above reads zero and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write at the clock edge, 0 = read only |
| req_page | input | PAGE_W | Page index |
| req_sel | input | 3 | Register selector (0 delivery, 1 threshold, 2 top identity, 3 pending word, 4 enable word) |
| req_index | input | 6 | Word index for pending and enable words |
| req_wdata | input | 32 | Write data |
| req_wmask | input | 32 | Per-bit write mask |
| rsp_rdata | output | 32 | Combinational read data for the current request |
| irq_o | output | NUM_PAGES | One interrupt line per page |

## Verification
Read data is a pure function of the current request and state, so the bench drives a read on a falling edge and samples `rsp_rdata` one time unit later, in the same cycle. A write changes state at the next rising edge. The interrupt lines and the top-identity value therefore change in that same edge's cycle, and the bench samples them one time unit after that edge, before the next request is driven. Every write updates a bench model at the same edge. After each write the bench compares all interrupt lines and at least one register read against that model, so a late or early update shows up as a mismatch.

// File: rtl/ipps_pkg.sv
package ipps_pkg;
   localparam int DATA_W     = 32;
   localparam int WORD_IDX_W = 6;
   localparam int ID_FIELD_W = 11;
   localparam int PRIO_SHIFT = 16;
   localparam int MAX_IDS    = 2048;

   typedef enum logic [2:0] {
      SEL_DELIV = 3'd0,
      SEL_THR   = 3'd1,
      SEL_TOP   = 3'd2,
      SEL_PEND  = 3'd3,
      SEL_ENAB  = 3'd4
   } ipps_sel_e;

   function automatic logic [DATA_W-1:0] pack_top(input logic [ID_FIELD_W-1:0] id);
      return (DATA_W'(id) << PRIO_SHIFT) | DATA_W'(id);
   endfunction
endpackage

// File: rtl/ipps_page_regs.sv
module ipps_page_regs import ipps_pkg::*; #(
   parameter int NUM_IDS = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [2:0]            sel,
   input  logic [WORD_IDX_W-1:0] widx,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [DATA_W-1:0]     wmask,
   input  logic [ID_FIELD_W-1:0] win_id,
   output logic [NUM_IDS-1:0]    pend_q,
   output logic [NUM_IDS-1:0]    en_q,
   output logic [DATA_W-1:0]     deliv_q,
   output logic [ID_FIELD_W-1:0] thr_q
);
   localparam int NUM_WORDS = NUM_IDS / DATA_W;

   logic claim_go;
   assign claim_go = (|wmask) && (win_id != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= '0;
         en_q    <= '0;
         deliv_q <= '0;
         thr_q   <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_DELIV: deliv_q <= (deliv_q & ~wmask) | (wdata & wmask);
            SEL_THR:   thr_q   <= (thr_q & ~wmask[ID_FIELD_W-1:0])
                                  | (wdata[ID_FIELD_W-1:0] & wmask[ID_FIELD_W-1:0]);
            SEL_TOP: begin
               if (claim_go) begin
                  for (int i = 1; i < NUM_IDS; i++) begin
                     if (ID_FIELD_W'(i) == win_id) pend_q[i] <= 1'b0;
                  end
               end
            end
            SEL_PEND: begin
               for (int w = 0; w < NUM_WORDS; w++) begin
                  if (widx == WORD_IDX_W'(w)) begin
                     for (int j = 0; j < DATA_W; j++) begin
                        if (wmask[j] && (w * DATA_W + j) != 0)
                           pend_q[w*DATA_W+j] <= wdata[j];
                     end
                  end
               end
            end
            SEL_ENAB: begin
               for (int w = 0; w < NUM_WORDS; w++) begin
                  if (widx == WORD_IDX_W'(w)) begin
                     for (int j = 0; j < DATA_W; j++) begin
                        if (wmask[j] && (w * DATA_W + j) != 0)
                           en_q[w*DATA_W+j] <= wdata[j];
                     end
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ipps_prio_scan.sv
module ipps_prio_scan import ipps_pkg::*; #(
   parameter int NUM_IDS = 64
) (
   input  logic [NUM_IDS-1:0]    pend,
   input  logic [NUM_IDS-1:0]    en,
   input  logic [ID_FIELD_W-1:0] thr,
   output logic [ID_FIELD_W-1:0] win_id,
   output logic [DATA_W-1:0]     top_val
);
   localparam int LIM_W = ID_FIELD_W + 1;

   logic [LIM_W-1:0]   limit;
   logic [NUM_IDS-1:0] eligible;

   always_comb begin
      if (thr != '0 && {1'b0, thr} <= LIM_W'(NUM_IDS)) limit = {1'b0, thr};
      else                                              limit = LIM_W'(NUM_IDS);
   end

   for (genvar i = 0; i < NUM_IDS; i++) begin : g_elig
      if (i == 0) begin : g_zero
         assign eligible[i] = 1'b0;
      end else begin : g_id
         assign eligible[i] = pend[i] && en[i] && (LIM_W'(i) < limit);
      end
   end

   always_comb begin
      win_id = '0;
      for (int i = NUM_IDS - 1; i >= 1; i--) begin
         if (eligible[i]) win_id = ID_FIELD_W'(i);
      end
   end

   assign top_val = pack_top(win_id);
endmodule

// File: rtl/page_irq_selector.sv
module page_irq_selector import ipps_pkg::*; #(
   parameter  int NUM_PAGES = 3,
   parameter  int NUM_IDS   = 64,
   localparam int PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [PAGE_W-1:0]     req_page,
   input  logic [2:0]            req_sel,
   input  logic [WORD_IDX_W-1:0] req_index,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [DATA_W-1:0]     req_wmask,
   output logic [DATA_W-1:0]     rsp_rdata,
   output logic [NUM_PAGES-1:0]  irq_o
);
   localparam int NUM_WORDS = NUM_IDS / DATA_W;

   if (NUM_PAGES < 1) begin : g_bad_pages
      $error("page_irq_selector: NUM_PAGES must be at least 1");
   end
   if (NUM_IDS < 64 || NUM_IDS > MAX_IDS || (NUM_IDS % 64) != 0) begin : g_bad_ids
      $error("page_irq_selector: NUM_IDS must be a multiple of 64 within 64..2048");
   end

   logic [NUM_PAGES-1:0][NUM_IDS-1:0]    pend_all;
   logic [NUM_PAGES-1:0][NUM_IDS-1:0]    en_all;
   logic [NUM_PAGES-1:0][DATA_W-1:0]     deliv_all;
   logic [NUM_PAGES-1:0][DATA_W-1:0]     top_all;
   logic [NUM_PAGES-1:0][ID_FIELD_W-1:0] thr_all;
   logic [NUM_PAGES-1:0][ID_FIELD_W-1:0] win_all;
   logic [NUM_PAGES-1:0]                 page_wr;

   for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
      assign page_wr[p] = req_valid && req_write && (req_page == PAGE_W'(p));

      ipps_page_regs #(.NUM_IDS(NUM_IDS)) u_regs (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (page_wr[p]),
         .sel     (req_sel),
         .widx    (req_index),
         .wdata   (req_wdata),
         .wmask   (req_wmask),
         .win_id  (win_all[p]),
         .pend_q  (pend_all[p]),
         .en_q    (en_all[p]),
         .deliv_q (deliv_all[p]),
         .thr_q   (thr_all[p])
      );

      ipps_prio_scan #(.NUM_IDS(NUM_IDS)) u_scan (
         .pend    (pend_all[p]),
         .en      (en_all[p]),
         .thr     (thr_all[p]),
         .win_id  (win_all[p]),
         .top_val (top_all[p])
      );

      assign irq_o[p] = (|deliv_all[p]) && (|top_all[p]);
   end

   always_comb begin
      rsp_rdata = '0;
      if (req_valid) begin
         for (int p = 0; p < NUM_PAGES; p++) begin
            if (req_page == PAGE_W'(p)) begin
               case (req_sel)
                  SEL_DELIV: rsp_rdata = deliv_all[p];
                  SEL_THR:   rsp_rdata = DATA_W'(thr_all[p]);
                  SEL_TOP:   rsp_rdata = top_all[p];
                  SEL_PEND: begin
                     for (int w = 0; w < NUM_WORDS; w++)
                        if (req_index == WORD_IDX_W'(w))
                           rsp_rdata = pend_all[p][w*DATA_W +: DATA_W];
                  end
                  SEL_ENAB: begin
                     for (int w = 0; w < NUM_WORDS; w++)
                        if (req_index == WORD_IDX_W'(w))
                           rsp_rdata = en_all[p][w*DATA_W +: DATA_W];
                  end
                  default: rsp_rdata = '0;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/page_irq_selector_chk.sv
module page_irq_selector_chk import ipps_pkg::*; #(
   parameter int NUM_PAGES = 3,
   parameter int NUM_IDS   = 64,
   parameter int PAGE_W    = 2
) (
   input logic                                 clk,
   input logic                                 rst_n,
   input logic                                 req_valid,
   input logic                                 req_write,
   input logic [PAGE_W-1:0]                    req_page,
   input logic [2:0]                           req_sel,
   input logic [DATA_W-1:0]                    req_wmask,
   input logic [NUM_PAGES-1:0]                 irq_o,
   input logic [NUM_PAGES-1:0][NUM_IDS-1:0]    pend_all,
   input logic [NUM_PAGES-1:0][NUM_IDS-1:0]    en_all,
   input logic [NUM_PAGES-1:0][ID_FIELD_W-1:0] thr_all,
   input logic [NUM_PAGES-1:0][DATA_W-1:0]     top_all
);
   localparam int LIM_W = ID_FIELD_W + 1;

   logic                    claim_q;
   logic [PAGE_W-1:0]       cpage_q;
   logic [DATA_W-1:0]       ctop_q;
   logic [DATA_W-1:0]       top_req;
   logic [DATA_W-1:0]       top_cpage;
   logic                    page_ok;

   always_comb begin
      top_req   = '0;
      top_cpage = '0;
      page_ok   = 1'b0;
      for (int p = 0; p < NUM_PAGES; p++) begin
         if (req_page == PAGE_W'(p)) begin
            top_req = top_all[p];
            page_ok = 1'b1;
         end
         if (cpage_q == PAGE_W'(p)) top_cpage = top_all[p];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         claim_q <= 1'b0;
         cpage_q <= '0;
         ctop_q  <= '0;
      end else begin
         claim_q <= req_valid && req_write && (req_sel == SEL_TOP) && (|req_wmask)
                    && page_ok && (top_req != '0);
         cpage_q <= req_page;
         ctop_q  <= top_req;
      end
   end

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_o == '0));

   assert_claim_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
      claim_q |-> (top_cpage != ctop_q));

   for (genvar p = 0; p < NUM_PAGES; p++) begin : g_pchk
      logic [NUM_IDS-1:0] hit;
      logic               win_hit;
      assign hit     = pend_all[p] & en_all[p];
      assign win_hit = |(hit & (NUM_IDS'(1) << top_all[p][ID_FIELD_W-1:0]));

      assert_id_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !pend_all[p][0] && !en_all[p][0]);

      assert_top_is_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (top_all[p] != '0) |-> win_hit);

      assert_under_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (thr_all[p] != '0 && {1'b0, thr_all[p]} <= LIM_W'(NUM_IDS) && top_all[p] != '0)
         |-> (top_all[p][ID_FIELD_W-1:0] < thr_all[p]));

      assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[p] |-> (|hit));
   end
endmodule

bind page_irq_selector page_irq_selector_chk #(
   .NUM_PAGES (NUM_PAGES),
   .NUM_IDS   (NUM_IDS),
   .PAGE_W    (PAGE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_page  (req_page),
   .req_sel   (req_sel),
   .req_wmask (req_wmask),
   .irq_o     (irq_o),
   .pend_all  (pend_all),
   .en_all    (en_all),
   .thr_all   (thr_all),
   .top_all   (top_all)
);

// File: tb/test_page_irq_selector.sv
module test_page_irq_selector;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 3;
   localparam int NI = 64;
   localparam int PW = 2;
   localparam int NW = NI / 32;
   localparam int S_DLV = 0, S_THR = 1, S_TOP = 2, S_PND = 3, S_ENB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [PW-1:0] req_page = '0;
   logic [2:0]    req_sel = '0;
   logic [5:0]    req_index = '0;
   logic [31:0]   req_wdata = '0;
   logic [31:0]   req_wmask = '0;
   logic [31:0]   rsp_rdata;
   logic [NP-1:0] irq_o;

   int n_checks = 0;
   int n_fail   = 0;

   bit        m_pend [NP][NI];
   bit        m_en   [NP][NI];
   bit [31:0] m_deliv[NP];
   bit [10:0] m_thr  [NP];

   page_irq_selector #(.NUM_PAGES(NP), .NUM_IDS(NI)) i_page_irq_selector (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_page(req_page), .req_sel(req_sel), .req_index(req_index),
      .req_wdata(req_wdata), .req_wmask(req_wmask), .rsp_rdata(rsp_rdata),
      .irq_o(irq_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic bit [31:0] m_top(int p);
      int lim;
      lim = (m_thr[p] != 0 && int'(m_thr[p]) <= NI) ? int'(m_thr[p]) : NI;
      for (int i = 1; i < lim; i++)
         if (m_pend[p][i] && m_en[p][i]) return (32'(i) << 16) | 32'(i);
      return 32'd0;
   endfunction

   function automatic bit [NP-1:0] m_irq();
      bit [NP-1:0] v;
      for (int p = 0; p < NP; p++) v[p] = (m_deliv[p] != 0) && (m_top(p) != 0);
      return v;
   endfunction

   function automatic bit [31:0] m_read(int p, int s, int idx);
      bit [31:0] v = '0;
      if (p >= NP) return '0;
      case (s)
         S_DLV: v = m_deliv[p];
         S_THR: v = 32'(m_thr[p]);
         S_TOP: v = m_top(p);
         S_PND, S_ENB: if (idx < NW)
            for (int j = 0; j < 32; j++)
               v[j] = (s == S_PND) ? m_pend[p][idx*32+j] : m_en[p][idx*32+j];
         default: v = '0;
      endcase
      return v;
   endfunction

   function automatic void m_write(int p, int s, int idx, bit [31:0] d, bit [31:0] m);
      bit [31:0] t;
      if (p >= NP) return;
      case (s)
         S_DLV: m_deliv[p] = (m_deliv[p] & ~m) | (d & m);
         S_THR: m_thr[p] = (m_thr[p] & ~m[10:0]) | (d[10:0] & m[10:0]);
         S_TOP: if (m != 0) begin
            t = m_top(p);
            if (t != 0) m_pend[p][t[10:0]] = 1'b0;
         end
         S_PND, S_ENB: if (idx < NW)
            for (int j = 0; j < 32; j++)
               if (m[j] && (idx*32+j) != 0) begin
                  if (s == S_PND) m_pend[p][idx*32+j] = d[j];
                  else            m_en[p][idx*32+j]   = d[j];
               end
         default: ;
      endcase
   endfunction

   task automatic chk(input bit [31:0] act, input bit [31:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(int p, int s, int idx, bit [31:0] d, bit [31:0] m);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_page = PW'(p); req_sel = 3'(s);
      req_index = 6'(idx); req_wdata = d; req_wmask = m;
      @(posedge clk);
      m_write(p, s, idx, d, m);
      #1 req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(int p, int s, int idx, output bit [31:0] v);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_page = PW'(p); req_sel = 3'(s);
      req_index = 6'(idx);
      #1 v = rsp_rdata;
      req_valid = 1'b0;
   endtask

   task automatic chk_reg(int p, int s, int idx, string tag);
      bit [31:0] v;
      rd(p, s, idx, v);
      chk(v, m_read(p, s, idx), tag);
   endtask

   task automatic chk_irq(string tag);
      chk(32'(irq_o), 32'(m_irq()), tag);
   endtask

   task automatic chk_all(string tag);
      for (int p = 0; p < NP + 1; p++) begin
         chk_reg(p, S_DLV, 0, tag);
         chk_reg(p, S_THR, 0, tag);
         chk_reg(p, S_TOP, 0, tag);
         for (int w = 0; w < NW; w++) begin
            chk_reg(p, S_PND, w, tag);
            chk_reg(p, S_ENB, w, tag);
         end
      end
      chk_irq(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog (R1..R8 run): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      bit [31:0] v;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: everything zero after reset
      chk(32'(irq_o), 32'd0, "R1 irq after reset");
      chk_all("R1 reset state");

      // R2: masked word writes, identity 0 read-only, out-of-range word
      wr(0, S_PND, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      rd(0, S_PND, 0, v); chk(v, 32'hFFFF_FFFE, "R2 identity 0 stays clear");
      wr(0, S_PND, 0, 32'h0, 32'h0000_FFFF);
      rd(0, S_PND, 0, v); chk(v, 32'hFFFF_0000, "R2 masked pend write");
      wr(0, S_ENB, 1, 32'hA5A5_A5A5, 32'h0F0F_0F0F);
      rd(0, S_ENB, 1, v); chk(v, 32'h0505_0505, "R2 masked enable write");
      wr(0, S_PND, 5, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      rd(0, S_PND, 5, v); chk(v, 32'h0, "R2 word index out of range");
      chk_all("R2 state after out-of-range write");
      for (int w = 0; w < NW; w++) begin
         wr(0, S_PND, w, 0, 32'hFFFF_FFFF);
         wr(0, S_ENB, w, 0, 32'hFFFF_FFFF);
      end

      // R3: lowest eligible identity wins
      wr(0, S_ENB, 0, 32'h20, 32'h20);
      wr(0, S_ENB, 1, 32'h100, 32'h100);
      wr(0, S_PND, 1, 32'h100, 32'h100);
      rd(0, S_TOP, 0, v); chk(v, 32'h0028_0028, "R3 single winner 40");
      wr(0, S_PND, 0, 32'h20, 32'h20);
      rd(0, S_TOP, 0, v); chk(v, 32'h0005_0005, "R3 lower identity wins");
      wr(0, S_PND, 0, 32'h08, 32'h08);
      rd(0, S_TOP, 0, v); chk(v, 32'h0005_0005, "R3 pending but disabled ignored");

      // R6: delivery gates the line
      chk(32'(irq_o), 32'd0, "R6 no delivery no line");
      wr(0, S_DLV, 0, 32'h1, 32'h1);
      chk(32'(irq_o), 32'd1, "R6 line rises after delivery write");

      // R4: threshold cut-off
      wr(0, S_THR, 0, 5, 32'hFFFF_FFFF);
      rd(0, S_TOP, 0, v); chk(v, 32'h0, "R4 threshold equal to winner");
      chk(32'(irq_o), 32'd0, "R6 line drops when nothing eligible");
      wr(0, S_THR, 0, 6, 32'hFFFF_FFFF);
      rd(0, S_TOP, 0, v); chk(v, 32'h0005_0005, "R4 threshold above winner");
      wr(0, S_THR, 0, 65, 32'hFFFF_FFFF);
      rd(0, S_TOP, 0, v); chk(v, 32'h0005_0005, "R4 threshold above id count");

      // R5: threshold width and delivery masking
      wr(0, S_THR, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      rd(0, S_THR, 0, v); chk(v, 32'h0000_07FF, "R5 threshold field width");
      rd(0, S_TOP, 0, v); chk(v, 32'h0005_0005, "R4 large threshold all eligible");
      wr(0, S_THR, 0, 0, 32'h7FF);
      wr(0, S_DLV, 0, 32'h1234_5678, 32'hFFFF_0000);
      rd(0, S_DLV, 0, v); chk(v, 32'h1234_0001, "R5 delivery masked write");

      // R7: claim
      wr(0, S_TOP, 0, 32'hFFFF_FFFF, 32'h0);
      rd(0, S_TOP, 0, v); chk(v, 32'h0005_0005, "R7 zero mask claim no effect");
      wr(0, S_TOP, 0, 32'h0, 32'h1);
      rd(0, S_TOP, 0, v); chk(v, 32'h0028_0028, "R7 claim clears winner");
      rd(0, S_ENB, 0, v); chk(v, 32'h20, "R7 claim keeps enable");
      rd(0, S_PND, 0, v); chk(v, 32'h08, "R7 claim clears only winner");
      wr(0, S_TOP, 0, 32'h5, 32'h80);
      rd(0, S_TOP, 0, v); chk(v, 32'h0, "R7 second claim");
      chk(32'(irq_o), 32'd0, "R6 line low after claims");
      wr(0, S_TOP, 0, 32'h5, 32'hFFFF_FFFF);
      chk_all("R7 claim without winner");

      // R8: page independence and out-of-range page
      wr(1, S_ENB, 1, 32'h8000_0000, 32'h8000_0000);
      wr(1, S_PND, 1, 32'h8000_0000, 32'h8000_0000);
      wr(1, S_DLV, 0, 32'h4, 32'h4);
      chk(32'(irq_o), 32'd2, "R8 only page 1 line");
      rd(1, S_TOP, 0, v); chk(v, 32'h003F_003F, "R8 page 1 top identity 63");
      wr(3, S_DLV, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      wr(3, S_PND, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      rd(3, S_DLV, 0, v); chk(v, 32'h0, "R8 out-of-range page reads zero");
      chk_all("R8 out-of-range page write ignored");

      // Random mix, R2..R8
      for (int n = 0; n < 600; n++) begin
         int p, s, idx;
         bit [31:0] d, m;
         p   = $urandom_range(NP, 0);
         s   = $urandom_range(4, 0);
         idx = $urandom_range(NW, 0);
         d   = $urandom;
         m   = ($urandom_range(3, 0) == 0) ? 32'hFFFF_FFFF : $urandom;
         if (s == S_THR && $urandom_range(1, 0) == 1) d = $urandom_range(NI + 2, 0);
         if (s == S_PND || s == S_ENB) d = d | $urandom;
         wr(p, s, idx, d, m);
         chk_irq("R6 random line");
         chk_reg($urandom_range(NP, 0), $urandom_range(4, 0), $urandom_range(NW, 0),
                 "R3 random readback");
         chk_reg(p, S_TOP, 0, "R7 random top");
      end
      chk_all("R8 final state");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule